// File: doc/BRIEF.md
# Configuration Data Clock Generator

This block sits between a 32-bit register write port and a device configuration bus. It drives the configuration clock (`dclk`) and the parallel data lines, `cfg_data`. Software first programs a control word. The control word sets the enable, chip-enable and configuration-pull pins, the number of clock pulses per data beat (x1, x2, x4 or x8) and the bus width (16 or 32 bits). Each data word written while data transfer is enabled is then placed on the bus. In 32-bit mode the word goes out as one beat. In 16-bit mode it goes out as two half-word beats, low half first.

The block can also send a burst of a programmed number of clock pulses that carry no new data. A sticky completion flag rises when such a burst ends. Software clears the flag by writing a one to it. `dclk` is a registered divide of the system clock. Each pulse is one system cycle low, with the data already stable, followed by one system cycle high.

The write port is valid/ready. A write completes on a rising edge of `clk` where `wr_valid` and `wr_ready` are both high. `wr_valid` may stay asserted while the port is stalled. While a data word or a burst is in progress, `wr_ready` is low for every address except the status register. Writes to the status register are always accepted.

Top module: `cfg_dclk_gen`

## Requirements
- R1: After reset, `dclk` and `cfg_data` are 0, `burst_done` is 0, `wr_ready` is 1, `cfg_en` and `cfg_nconfig_pull` are 0, and `cfg_nce` is 1.
- R2: A write to address 0x04 loads the control word in the cycle after it is accepted. The fields are: bit 0 drives `cfg_en`, bit 1 drives `cfg_nce`, bit 2 drives `cfg_nconfig_pull`, bits 7:6 select the ratio (0 = x1, 1 = x2, 2 = x4, 3 = x8), bit 8 enables data transfer, and bit 9 selects the bus width (0 = 16-bit, 1 = 32-bit).
- R3: A write to the data address 0x10 while bit 8 of the control word is 0 is accepted and discarded. No `dclk` pulse follows and `cfg_data` keeps its value.
- R4: In 32-bit mode an accepted data word appears whole on `cfg_data` for one beat.
- R5: In 16-bit mode an accepted data word is sent as two beats. The first beat carries bits 15:0 and the second carries bits 31:16, each on `cfg_data[15:0]` with `cfg_data[31:16]` at zero.
- R6: Each beat lasts ratio `dclk` pulses. Each pulse is one cycle low followed by one cycle high. The first low cycle is the cycle after acceptance. `cfg_data` never changes while `dclk` is high.
- R7: `wr_nbytes` gives the number of valid bytes of a data word. A value of 0 means all four bytes are valid. Values 1, 2 and 3 keep that many low bytes and zero the rest.
- R8: A write of N > 0 to address 0x08 produces N `dclk` pulses while `cfg_data` holds its value. `burst_done` rises in the cycle after the last high phase. A write of 0 produces nothing.
- R9: `burst_done` stays set until a write to address 0x0C with bit 0 set. A write with bit 0 clear leaves it unchanged. If a clear falls in the same cycle as a burst end, the flag stays set.
- R10: While a word or a burst is in progress, `wr_ready` is 0 for every address other than 0x0C. Writes to 0x0C are accepted in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request can be accepted this cycle |
| wr_addr | input | 5 | Byte address of the register written |
| wr_data | input | 32 | Write data |
| wr_nbytes | input | 2 | Valid byte count for data words, 0 = all four |
| cfg_en | output | 1 | Control bit 0 |
| cfg_nce | output | 1 | Control bit 1, device chip enable (active low) |
| cfg_nconfig_pull | output | 1 | Control bit 2, holds the device in reset |
| dclk | output | 1 | Configuration clock |
| cfg_data | output | 32 | Configuration data bus |
| burst_done | output | 1 | Sticky flag set when a pulse burst ends |

## Verification
The status port stays open during a burst, so the write-one-to-clear of `burst_done` can land in the same cycle as the burst's final high phase. The bench provokes this by issuing a burst of three pulses and timing a clear write to be accepted exactly six cycles later. The expected result is that the flag stays set; a later clear must then remove it. The reference model applies the set after the clear in that cycle and compares the flag on every clock.

// File: rtl/cfgdclk_pkg.sv
package cfgdclk_pkg;

  // Register byte offsets; the count and status offsets are fixed by software.
  localparam logic [7:0] OFS_CTRL  = 8'h04;
  localparam logic [7:0] OFS_COUNT = 8'h08;
  localparam logic [7:0] OFS_STAT  = 8'h0C;
  localparam logic [7:0] OFS_DATA  = 8'h10;

  // Bit positions inside the control word
  localparam int CB_EN    = 0;
  localparam int CB_NCE   = 1;
  localparam int CB_PULL  = 2;
  localparam int CB_RATLO = 6;
  localparam int CB_XFER  = 8;
  localparam int CB_WIDE  = 9;

  typedef struct packed {
    logic       wide;   // 1: 32-bit bus, 0: 16-bit bus
    logic       xfer;   // data words accepted onto the bus
    logic [1:0] ratio;  // log2 of pulses per beat
    logic       pull;
    logic       nce;
    logic       en;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{wide: 1'b0, xfer: 1'b0, ratio: 2'd0,
                                   pull: 1'b0, nce: 1'b1, en: 1'b0};

  function automatic logic [3:0] beat_pulses(input logic [1:0] r);
    return 4'd1 << r;
  endfunction

endpackage

// File: rtl/cfgdclk_ctrl_regs.sv
module cfgdclk_ctrl_regs
  import cfgdclk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              stat_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              burst_fin,
  output ctrl_t             ctrl,
  output logic              done
);

  ctrl_t ctrl_q;
  logic  done_q;

  // Bits with no field in either register
  logic unused_wdata_bits;
  assign unused_wdata_bits = ^{wdata[DATA_W-1:CB_WIDE+1], wdata[CB_RATLO-1:CB_PULL+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
    end else if (ctrl_we) begin
      ctrl_q.en    <= wdata[CB_EN];
      ctrl_q.nce   <= wdata[CB_NCE];
      ctrl_q.pull  <= wdata[CB_PULL];
      ctrl_q.ratio <= wdata[CB_RATLO+1:CB_RATLO];
      ctrl_q.xfer  <= wdata[CB_XFER];
      ctrl_q.wide  <= wdata[CB_WIDE];
    end
  end

  // Completion flag: a finishing burst outranks a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (burst_fin) begin
      done_q <= 1'b1;
    end else if (stat_we && wdata[0]) begin
      done_q <= 1'b0;
    end
  end

  assign ctrl = ctrl_q;
  assign done = done_q;

endmodule

// File: rtl/cfgdclk_pulse_gen.sv
module cfgdclk_pulse_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] n_pulses,
  output logic             dclk,
  output logic             busy,
  output logic             tick,
  output logic             last
);

  logic             busy_q;
  logic             high_q;
  logic [CNT_W-1:0] left_q;

  // Each pulse: one low cycle then one high cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      high_q <= 1'b0;
      left_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        high_q <= 1'b0;
        left_q <= n_pulses;
      end
    end else if (!high_q) begin
      high_q <= 1'b1;
    end else begin
      high_q <= 1'b0;
      left_q <= left_q - 1'b1;
      if (left_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  assign dclk = busy_q & high_q;
  assign busy = busy_q;
  assign tick = dclk;
  assign last = dclk && (left_q == CNT_W'(1));

endmodule

// File: rtl/cfgdclk_word_ser.sv
module cfgdclk_word_ser
  import cfgdclk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] word,
  input  logic              wide,
  input  logic [1:0]        ratio,
  input  logic              tick,
  output logic [DATA_W-1:0] data_out
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] word_q;
  logic              wide_q;
  logic [3:0]        per_beat_q;
  logic [3:0]        cnt_q;
  logic              upper_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q     <= '0;
      wide_q     <= 1'b1;
      per_beat_q <= 4'd1;
      cnt_q      <= '0;
      upper_q    <= 1'b0;
    end else if (load) begin
      word_q     <= word;
      wide_q     <= wide;
      per_beat_q <= beat_pulses(ratio);
      cnt_q      <= '0;
      upper_q    <= 1'b0;
    end else if (tick) begin
      if (cnt_q == per_beat_q - 4'd1) begin
        cnt_q   <= '0;
        upper_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 4'd1;
      end
    end
  end

  always_comb begin
    if (wide_q) begin
      data_out = word_q;
    end else if (upper_q) begin
      data_out = {{HALF_W{1'b0}}, word_q[DATA_W-1:HALF_W]};
    end else begin
      data_out = {{HALF_W{1'b0}}, word_q[HALF_W-1:0]};
    end
  end

endmodule

// File: rtl/cfg_dclk_gen.sv
module cfg_dclk_gen
  import cfgdclk_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_nbytes,
  output logic              cfg_en,
  output logic              cfg_nce,
  output logic              cfg_nconfig_pull,
  output logic              dclk,
  output logic [DATA_W-1:0] cfg_data,
  output logic              burst_done
);

  localparam int NBYTES = DATA_W / 8;

  ctrl_t             ctrl;
  logic              busy, tick, last;
  logic              hit_ctrl, hit_count, hit_stat, hit_data;
  logic              acc, start_word, start_burst, burst_fin;
  logic              burst_mode_q;
  logic [CNT_W-1:0]  count_val, word_pulses, n_pulses;
  logic [DATA_W-1:0] masked;

  assign hit_ctrl  = (wr_addr == OFS_CTRL[ADDR_W-1:0]);
  assign hit_count = (wr_addr == OFS_COUNT[ADDR_W-1:0]);
  assign hit_stat  = (wr_addr == OFS_STAT[ADDR_W-1:0]);
  assign hit_data  = (wr_addr == OFS_DATA[ADDR_W-1:0]);

  // Status writes bypass the back-pressure.
  assign wr_ready = !busy || hit_stat;
  assign acc      = wr_valid && wr_ready;

  assign count_val   = wr_data[CNT_W-1:0];
  assign start_word  = acc && hit_data && ctrl.xfer;
  assign start_burst = acc && hit_count && (count_val != '0);

  // Partial final word: keep only the low wr_nbytes bytes.
  for (genvar b = 0; b < NBYTES; b++) begin : g_mask
    assign masked[8*b +: 8] = ((wr_nbytes == 2'd0) || (int'(wr_nbytes) > b))
                              ? wr_data[8*b +: 8] : 8'h00;
  end

  assign word_pulses = ctrl.wide ? CNT_W'(beat_pulses(ctrl.ratio))
                                 : CNT_W'(beat_pulses(ctrl.ratio)) << 1;
  assign n_pulses    = start_burst ? count_val : word_pulses;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_mode_q <= 1'b0;
    end else if (start_word || start_burst) begin
      burst_mode_q <= start_burst;
    end
  end

  assign burst_fin = last && burst_mode_q;

  cfgdclk_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (acc && hit_ctrl),
    .stat_we   (acc && hit_stat),
    .wdata     (wr_data),
    .burst_fin (burst_fin),
    .ctrl      (ctrl),
    .done      (burst_done)
  );

  cfgdclk_pulse_gen #(.CNT_W(CNT_W)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_word || start_burst),
    .n_pulses (n_pulses),
    .dclk     (dclk),
    .busy     (busy),
    .tick     (tick),
    .last     (last)
  );

  cfgdclk_word_ser #(.DATA_W(DATA_W)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_word),
    .word     (masked),
    .wide     (ctrl.wide),
    .ratio    (ctrl.ratio),
    .tick     (tick && !burst_mode_q),
    .data_out (cfg_data)
  );

  assign cfg_en           = ctrl.en;
  assign cfg_nce          = ctrl.nce;
  assign cfg_nconfig_pull = ctrl.pull;

endmodule

// File: rtl/cfg_dclk_gen_chk.sv
module cfg_dclk_gen_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              dclk,
  input logic [DATA_W-1:0] cfg_data,
  input logic              burst_done
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(12);

  AST_HIGH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |=> !dclk);  // R6

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |-> $stable(cfg_data));  // R6

  AST_STALL_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |-> (!wr_ready || wr_addr == A_STAT));  // R10

  AST_STATUS_ALWAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr == A_STAT) |-> wr_ready);  // R10

  AST_DONE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_done) |-> $past(dclk));  // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && !(wr_valid && wr_ready && wr_addr == A_STAT && wr_data[0]))
      |=> burst_done);  // R9

endmodule

bind cfg_dclk_gen cfg_dclk_gen_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .dclk       (dclk),
  .cfg_data   (cfg_data),
  .burst_done (burst_done)
);

// File: tb/sim_cfg_dclk_gen.sv
`timescale 1ns/1ps
module sim_cfg_dclk_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  wr_nbytes = '0;
  logic        cfg_en, cfg_nce, cfg_nconfig_pull, dclk, burst_done;
  logic [31:0] cfg_data;

  always #2 clk = ~clk;  // 250 MHz

  cfg_dclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_nbytes(wr_nbytes),
    .cfg_en(cfg_en), .cfg_nce(cfg_nce), .cfg_nconfig_pull(cfg_nconfig_pull),
    .dclk(dclk), .cfg_data(cfg_data), .burst_done(burst_done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int n_pulse = 0;
  int cyc = 0;

  // ---------------- reference model: one queue entry per future cycle
  typedef struct { bit d; logic [31:0] v; bit fin; } ent_t;
  ent_t        q[$];
  logic [9:0]  m_ctrl = 10'h002;
  logic [31:0] m_last = '0;
  bit          m_done = 1'b0;

  function automatic void push_pulses(logic [31:0] v, int n, bit is_burst);
    for (int i = 0; i < n; i++) begin
      q.push_back('{d: 1'b0, v: v, fin: 1'b0});
      q.push_back('{d: 1'b1, v: v, fin: is_burst && (i == n - 1)});
    end
  endfunction

  function automatic logic [31:0] keep(logic [31:0] w, logic [1:0] nb);
    logic [31:0] r = w;
    if (nb != 0)
      for (int b = 0; b < 4; b++) if (b >= nb) r[8*b +: 8] = 8'h00;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_ctrl = 10'h002; m_last = '0; m_done = 1'b0;
    end else begin
      bit acc, fin;
      acc = wr_valid && (q.size() == 0 || wr_addr == 5'h0C);
      fin = 1'b0;
      if (q.size() != 0) begin
        fin = q[0].fin; m_last = q[0].v; void'(q.pop_front());
      end
      if (acc && wr_addr == 5'h0C && wr_data[0]) m_done = 1'b0;
      if (fin) m_done = 1'b1;
      if (acc) begin
        case (wr_addr)
          5'h04: m_ctrl = wr_data[9:0];
          5'h08: if (wr_data[15:0] != 0) push_pulses(m_last, int'(wr_data[15:0]), 1'b1);
          5'h10: if (m_ctrl[8]) begin
            logic [31:0] w;
            int r;
            w = keep(wr_data, wr_nbytes);
            r = 1 << m_ctrl[7:6];
            if (m_ctrl[9]) push_pulses(w, r, 1'b0);
            else begin
              push_pulses({16'h0, w[15:0]}, r, 1'b0);
              push_pulses({16'h0, w[31:16]}, r, 1'b0);
            end
          end
          default: ;
        endcase
      end
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    bit          e_d;
    logic [31:0] e_v;
    e_d = (q.size() != 0) ? q[0].d : 1'b0;
    e_v = (q.size() != 0) ? q[0].v : m_last;
    if (dclk === 1'b1) n_pulse++;
    cmp("R6 dclk", {31'h0, dclk}, {31'h0, e_d});
    cmp("R4 R5 R7 R8 cfg_data", cfg_data, e_v);
    cmp("R10 wr_ready", {31'h0, wr_ready},
        {31'h0, (q.size() == 0) || (wr_addr == 5'h0C)});
    cmp("R8 R9 burst_done", {31'h0, burst_done}, {31'h0, m_done});
    cmp("R2 control pins", {29'h0, cfg_nconfig_pull, cfg_nce, cfg_en},
        {29'h0, m_ctrl[2:0]});
  end

  // ---------------- stimulus helpers
  task automatic wr(logic [4:0] a, logic [31:0] d, logic [1:0] nb);
    bit rdy;
    @(negedge clk); #1;
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_nbytes = nb;
    forever begin
      #0.5 rdy = wr_ready;
      @(posedge clk);
      if (rdy) break;
    end
    #1 wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0);
    repeat (2) @(negedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired, all requirements R1 to R10 unfinished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1: reset values
    cmp("R1 dclk reset", {31'h0, dclk}, 32'h0);
    cmp("R1 cfg_data reset", cfg_data, 32'h0);
    cmp("R1 done reset", {31'h0, burst_done}, 32'h0);
    cmp("R1 ready reset", {31'h0, wr_ready}, 32'h1);
    cmp("R1 nce reset", {31'h0, cfg_nce}, 32'h1);
    rst_n = 1'b1;

    // R3: data discarded while transfer disabled
    p0 = n_pulse;
    wr(5'h10, 32'hDEADBEEF, 2'd0);
    wait_idle();
    cmp("R3 no pulses when disabled", n_pulse - p0, 0);
    cmp("R3 data unchanged when disabled", cfg_data, 32'h0);

    // R2 R4: x1, 32-bit, two back-to-back words
    wr(5'h04, 32'h0000_0301, 2'd0);
    wr(5'h10, 32'h1234_5678, 2'd0);
    wr(5'h10, 32'hA5A5_F00F, 2'd0);
    wait_idle();

    // R5 R6: x2, 16-bit
    p0 = n_pulse;
    wr(5'h04, 32'h0000_0141, 2'd0);
    wr(5'h10, 32'hCAFE_BABE, 2'd0);
    wait_idle();
    cmp("R5 R6 pulses for x2 16-bit word", n_pulse - p0, 4);

    // R7: x4, 32-bit, partial words
    wr(5'h04, 32'h0000_0385, 2'd0);
    wr(5'h10, 32'h1122_3344, 2'd1);
    wr(5'h10, 32'h5566_7788, 2'd2);
    wr(5'h10, 32'h99AA_BBCC, 2'd3);
    wait_idle();
    cmp("R7 three-byte word", cfg_data, 32'h00AA_BBCC);

    // R5 R6 R7: x8, 16-bit, three-byte word
    p0 = n_pulse;
    wr(5'h04, 32'h0000_01C1, 2'd0);
    wr(5'h10, 32'h89AB_CDEF, 2'd3);
    wait_idle();
    cmp("R6 pulses for x8 16-bit word", n_pulse - p0, 16);
    cmp("R5 high half last", cfg_data, 32'h0000_00AB);

    // R8: burst of 5
    p0 = n_pulse;
    wr(5'h08, 32'd5, 2'd0);
    wait_idle();
    cmp("R8 burst pulse count", n_pulse - p0, 5);
    cmp("R8 done set", {31'h0, burst_done}, 32'h1);
    cmp("R8 data held through burst", cfg_data, 32'h0000_00AB);

    // R9: write of 0 keeps flag, write of 1 clears
    wr(5'h0C, 32'h0000_0000, 2'd0);
    @(negedge clk); #1;
    cmp("R9 zero write keeps done", {31'h0, burst_done}, 32'h1);
    wr(5'h0C, 32'h0000_0001, 2'd0);
    @(negedge clk); #1;
    cmp("R9 clear", {31'h0, burst_done}, 32'h0);

    // R8: zero count does nothing
    p0 = n_pulse;
    wr(5'h08, 32'd0, 2'd0);
    wait_idle();
    cmp("R8 zero count no pulses", n_pulse - p0, 0);
    cmp("R8 zero count no done", {31'h0, burst_done}, 32'h0);

    // R9 R10: clear lands in the final high cycle of a 3-pulse burst
    wr(5'h08, 32'd3, 2'd0);
    repeat (5) @(posedge clk);
    wr(5'h0C, 32'h0000_0001, 2'd0);
    @(negedge clk); #1;
    cmp("R9 set wins over coincident clear", {31'h0, burst_done}, 32'h1);
    wr(5'h0C, 32'h0000_0001, 2'd0);
    @(negedge clk); #1;
    cmp("R9 later clear", {31'h0, burst_done}, 32'h0);

    // R10: data write stalls behind a burst, then goes out (x1, 32-bit)
    wr(5'h04, 32'h0000_0300, 2'd0);
    wr(5'h08, 32'd4, 2'd0);
    wr(5'h10, 32'h0BAD_F00D, 2'd0);
    wait_idle();
    cmp("R10 stalled word delivered", cfg_data, 32'h0BAD_F00D);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule